// File: doc/BRIEF.md
# Register-Machine Bytecode Format Decoder

This block takes a stream of 16-bit code units, each offered with a valid/ready handshake, and turns them into decoded instruction records. The low byte of the first unit of an instruction is the opcode. The opcode selects one of the fixed instruction formats, and the format sets how many units the instruction has, from 1 to 5. The block collects that many units and then presents one record. The record holds:

- the opcode
- a numeric format code
- the length in units
- the register fields
- the argument-list count, registers and valid mask
- a 64-bit sign-extended immediate or branch offset
- a 32-bit constant-pool index
- an invalid flag for unused opcodes
- a payload flag for data-table headers

A record stays on the output until the consumer takes it. While the record is held, no new unit is taken in. A synchronous flush drops a partly collected instruction, and decoding starts again at the next unit offered.

Top module: `bcode_fmt_decoder`

## Requirements
- R1: `op_o` is the low byte of the first unit. `fmt_o` gives the format as a code: 0=10x, 1=12x, 2=11n, 3=11x, 4=10t, 5=20t, 6=22x, 7=21t, 8=21s, 9=21h, 10=21c, 11=23x, 12=22b, 13=22t, 14=22s, 15=22c, 16=30t, 17=32x, 18=31i, 19=31t, 20=31c, 21=35c, 22=3rc, 23=51l. `len_o` is the first digit of the format name, and exactly that many units are consumed.
- R2: Register fields come from these positions.
  - Nibble formats (12x, 11n, 22t, 22s, 22c): `reg_a_o` is unit0[11:8] and `reg_b_o` is unit0[15:12].
  - Byte-register formats: `reg_a_o` is unit0[15:8].
  - 22x: `reg_b_o` is unit1.
  - 23x: `reg_b_o` is unit1[7:0] and `reg_c_o` is unit1[15:8].
  - 22b: `reg_b_o` is unit1[7:0].
  - 32x: `reg_a_o` is unit1 and `reg_b_o` is unit2.
  - Fields a format does not use read zero.
- R3: Wide operands are assembled lowest unit first.
  - 31i, 30t and 31t: 32 bits from {unit2, unit1}, sign-extended into `imm_o`.
  - 31c: `index_o` is {unit2, unit1}.
  - 51l: `imm_o` is {unit4, unit3, unit2, unit1}.
- R4: For 35c, the fields are as follows.
  - `arg_cnt_o` is unit0[15:12] and `index_o` is unit1.
  - `arg_regs_o` is {unit0[11:8], unit2}, which places the registers C,D,E,F,G at nibbles 0 to 4.
  - Bit i of `arg_vld_o` is set exactly when i < `arg_cnt_o`.
- R5: For 3rc, `arg_cnt_o` is unit0[15:8], `index_o` is unit1 and `reg_c_o` is unit2, the first register. For 21c and 22c, `index_o` is unit1.
- R6: Opcodes 3e–43, 73, 79–7a and e3–ff give a one-unit record with `fmt_o`=0 and `invalid_o`=1, and every operand field reads zero.
- R7: Opcode 00 with a nonzero high byte sets `payload_o`=1. Opcode 00 with a zero high byte is a plain no-op with `payload_o`=0.
- R8: Immediates are sign-extended to 64 bits from these fields:
  - 11n: unit0[15:12]
  - 22b: unit1[15:8]
  - 10t: unit0[15:8]
  - 21s, 22s, 21t, 22t and 20t: unit1
- R9: For 21h with opcode 15, `imm_o` is {unit1, 16'h0} sign-extended to 64 bits. With opcode 19, `imm_o` is {unit1, 48'h0}.
- R10: While `out_valid_o`=1 and `out_ready_i`=0, the record stays unchanged in the next cycle and `in_ready_o` is 0.
- R11: While `flush_i`=1, no unit is taken. A partly collected instruction is dropped and produces no record.
- R12: After reset, `out_valid_o`=0 and `in_ready_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Drops a partly collected instruction |
| in_valid_i | input | 1 | Code unit offered |
| in_data_i | input | 16 | Code unit |
| in_ready_o | output | 1 | Code unit taken this cycle |
| out_valid_o | output | 1 | Record available |
| out_ready_i | input | 1 | Record taken by consumer |
| op_o | output | 8 | Opcode |
| fmt_o | output | 5 | Format code (R1) |
| len_o | output | 3 | Length in units |
| reg_a_o | output | 16 | Register field A |
| reg_b_o | output | 16 | Register field B |
| reg_c_o | output | 16 | Register field C / first range register |
| arg_cnt_o | output | 8 | Argument count (35c, 3rc) |
| arg_regs_o | output | 20 | Argument registers C..G, 4 bits each (35c) |
| arg_vld_o | output | 5 | Valid mask over arg_regs_o |
| imm_o | output | 64 | Immediate or branch offset |
| index_o | output | 32 | Constant-pool index |
| invalid_o | output | 1 | Unused opcode |
| payload_o | output | 1 | Payload header unit |

## Verification
The bench runs every length from one to five units while the consumer stalls in a fixed rhythm.

- A decoder that counted units wrongly would fall out of step on the next opcode, and every record after it would be wrong.
- Negative values sit at each sign-extension width, and both high-half constant variants are covered. A wrong extension width or a mixed-up 32/64-bit placement shows up as a wrong upper word.
- Argument lists of three and five entries check the valid mask against the count.
- A flush in the middle of an instruction must leave no record behind. A decoder that kept the partial unit would emit an extra or merged record.

// File: rtl/bcode_pkg.sv
package bcode_pkg;
  localparam int UNIT_W    = 16;
  localparam int MAX_UNITS = 5;
  localparam int CNT_W     = $clog2(MAX_UNITS + 1);
  localparam int OP_W      = 8;
  localparam int NIB_W     = 4;
  localparam int IMM_W     = 64;
  localparam int IDX_W     = 32;
  localparam int ARG_N     = 5;

  typedef enum logic [4:0] {
    F10X = 5'd0,  F12X = 5'd1,  F11N = 5'd2,  F11X = 5'd3,
    F10T = 5'd4,  F20T = 5'd5,  F22X = 5'd6,  F21T = 5'd7,
    F21S = 5'd8,  F21H = 5'd9,  F21C = 5'd10, F23X = 5'd11,
    F22B = 5'd12, F22T = 5'd13, F22S = 5'd14, F22C = 5'd15,
    F30T = 5'd16, F32X = 5'd17, F31I = 5'd18, F31T = 5'd19,
    F31C = 5'd20, F35C = 5'd21, F3RC = 5'd22, F51L = 5'd23
  } fmt_e;

  typedef logic [MAX_UNITS-1:0][UNIT_W-1:0] unit_buf_t;

  function automatic logic [CNT_W-1:0] fmt_len(fmt_e f);
    case (f)
      F10X, F12X, F11N, F11X, F10T:             return CNT_W'(1);
      F20T, F22X, F21T, F21S, F21H, F21C,
      F23X, F22B, F22T, F22S, F22C:             return CNT_W'(2);
      F30T, F32X, F31I, F31T, F31C, F35C, F3RC: return CNT_W'(3);
      F51L:                                     return CNT_W'(5);
      default:                                  return CNT_W'(1);
    endcase
  endfunction
endpackage

// File: rtl/bcode_fmt_lut.sv
module bcode_fmt_lut
  import bcode_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output fmt_e            fmt_o,
  output logic            unused_o
);
  always_comb begin
    unused_o = 1'b0;
    fmt_o    = F10X;
    case (op_i) inside
      8'h00, 8'h0e:                                   fmt_o = F10X;
      8'h01, 8'h04, 8'h07, 8'h21,
      [8'h7b:8'h8f], [8'hb0:8'hcf]:                   fmt_o = F12X;
      8'h02, 8'h05, 8'h08:                            fmt_o = F22X;
      8'h03, 8'h06, 8'h09:                            fmt_o = F32X;
      [8'h0a:8'h0d], [8'h0f:8'h11], 8'h1d, 8'h1e,
      8'h27:                                          fmt_o = F11X;
      8'h12:                                          fmt_o = F11N;
      8'h13, 8'h16:                                   fmt_o = F21S;
      8'h14, 8'h17:                                   fmt_o = F31I;
      8'h15, 8'h19:                                   fmt_o = F21H;
      8'h18:                                          fmt_o = F51L;
      8'h1a, 8'h1c, 8'h1f, 8'h22, [8'h60:8'h6d]:      fmt_o = F21C;
      8'h1b:                                          fmt_o = F31C;
      8'h20, 8'h23, [8'h52:8'h5f]:                    fmt_o = F22C;
      8'h24, [8'h6e:8'h72]:                           fmt_o = F35C;
      8'h25, [8'h74:8'h78]:                           fmt_o = F3RC;
      8'h26, 8'h2b, 8'h2c:                            fmt_o = F31T;
      8'h28:                                          fmt_o = F10T;
      8'h29:                                          fmt_o = F20T;
      8'h2a:                                          fmt_o = F30T;
      [8'h2d:8'h31], [8'h44:8'h51], [8'h90:8'haf]:    fmt_o = F23X;
      [8'h32:8'h37]:                                  fmt_o = F22T;
      [8'h38:8'h3d]:                                  fmt_o = F21T;
      [8'hd0:8'hd7]:                                  fmt_o = F22S;
      [8'hd8:8'he2]:                                  fmt_o = F22B;
      default: begin
        fmt_o    = F10X;
        unused_o = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/bcode_field_extract.sv
module bcode_field_extract
  import bcode_pkg::*;
(
  input  fmt_e                   fmt_i,
  input  unit_buf_t              u_i,
  output logic [UNIT_W-1:0]      reg_a_o,
  output logic [UNIT_W-1:0]      reg_b_o,
  output logic [UNIT_W-1:0]      reg_c_o,
  output logic [OP_W-1:0]        arg_cnt_o,
  output logic [ARG_N*NIB_W-1:0] arg_regs_o,
  output logic [ARG_N-1:0]       arg_vld_o,
  output logic [IMM_W-1:0]       imm_o,
  output logic [IDX_W-1:0]       index_o
);
  logic [UNIT_W-1:0] u0, u1, u2, u3, u4;
  logic [31:0]       w21;

  assign u0  = u_i[0];
  assign u1  = u_i[1];
  assign u2  = u_i[2];
  assign u3  = u_i[3];
  assign u4  = u_i[4];
  assign w21 = {u2, u1};

  always_comb begin
    reg_a_o    = '0;
    reg_b_o    = '0;
    reg_c_o    = '0;
    arg_cnt_o  = '0;
    arg_regs_o = '0;
    imm_o      = '0;
    index_o    = '0;
    case (fmt_i)
      F12X: begin
        reg_a_o = 16'(u0[11:8]);
        reg_b_o = 16'(u0[15:12]);
      end
      F11N: begin
        reg_a_o = 16'(u0[11:8]);
        imm_o   = {{60{u0[15]}}, u0[15:12]};
      end
      F11X: reg_a_o = 16'(u0[15:8]);
      F10T: imm_o = {{56{u0[15]}}, u0[15:8]};
      F20T: imm_o = {{48{u1[15]}}, u1};
      F22X: begin
        reg_a_o = 16'(u0[15:8]);
        reg_b_o = u1;
      end
      F21T, F21S: begin
        reg_a_o = 16'(u0[15:8]);
        imm_o   = {{48{u1[15]}}, u1};
      end
      F21H: begin
        reg_a_o = 16'(u0[15:8]);
        // wide variant puts the half-word at the very top
        if (u0[7:0] == 8'h19) imm_o = {u1, 48'h0};
        else                  imm_o = {{32{u1[15]}}, u1, 16'h0};
      end
      F21C: begin
        reg_a_o = 16'(u0[15:8]);
        index_o = 32'(u1);
      end
      F23X: begin
        reg_a_o = 16'(u0[15:8]);
        reg_b_o = 16'(u1[7:0]);
        reg_c_o = 16'(u1[15:8]);
      end
      F22B: begin
        reg_a_o = 16'(u0[15:8]);
        reg_b_o = 16'(u1[7:0]);
        imm_o   = {{56{u1[15]}}, u1[15:8]};
      end
      F22T, F22S: begin
        reg_a_o = 16'(u0[11:8]);
        reg_b_o = 16'(u0[15:12]);
        imm_o   = {{48{u1[15]}}, u1};
      end
      F22C: begin
        reg_a_o = 16'(u0[11:8]);
        reg_b_o = 16'(u0[15:12]);
        index_o = 32'(u1);
      end
      F30T: imm_o = {{32{w21[31]}}, w21};
      F32X: begin
        reg_a_o = u1;
        reg_b_o = u2;
      end
      F31I, F31T: begin
        reg_a_o = 16'(u0[15:8]);
        imm_o   = {{32{w21[31]}}, w21};
      end
      F31C: begin
        reg_a_o = 16'(u0[15:8]);
        index_o = w21;
      end
      F35C: begin
        arg_cnt_o  = 8'(u0[15:12]);
        arg_regs_o = {u0[11:8], u2};
        index_o    = 32'(u1);
      end
      F3RC: begin
        arg_cnt_o = u0[15:8];
        index_o   = 32'(u1);
        reg_c_o   = u2;
      end
      F51L: begin
        reg_a_o = 16'(u0[15:8]);
        imm_o   = {u4, u3, u2, u1};
      end
      default: ;
    endcase
  end

  for (genvar i = 0; i < ARG_N; i++) begin : g_vld
    assign arg_vld_o[i] = (fmt_i == F35C) && (u0[15:12] > NIB_W'(i));
  end
endmodule

// File: rtl/bcode_fmt_decoder.sv
module bcode_fmt_decoder
  import bcode_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   flush_i,
  input  logic                   in_valid_i,
  input  logic [15:0]            in_data_i,
  output logic                   in_ready_o,
  output logic                   out_valid_o,
  input  logic                   out_ready_i,
  output logic [7:0]             op_o,
  output logic [4:0]             fmt_o,
  output logic [2:0]             len_o,
  output logic [15:0]            reg_a_o,
  output logic [15:0]            reg_b_o,
  output logic [15:0]            reg_c_o,
  output logic [7:0]             arg_cnt_o,
  output logic [19:0]            arg_regs_o,
  output logic [4:0]             arg_vld_o,
  output logic [63:0]            imm_o,
  output logic [31:0]            index_o,
  output logic                   invalid_o,
  output logic                   payload_o
);
  unit_buf_t        units_q;
  logic [CNT_W-1:0] cnt_q, len_q, need_len, cnt_nxt, in_len;
  logic             out_vld_q, accept;
  fmt_e             in_fmt, rec_fmt;
  logic             in_unused, rec_unused;

  bcode_fmt_lut i_in_lut (
    .op_i     (in_data_i[7:0]),
    .fmt_o    (in_fmt),
    .unused_o (in_unused)
  );

  bcode_fmt_lut i_rec_lut (
    .op_i     (units_q[0][7:0]),
    .fmt_o    (rec_fmt),
    .unused_o (rec_unused)
  );

  assign in_len     = fmt_len(in_fmt);
  assign need_len   = (cnt_q == '0) ? in_len : len_q;
  assign cnt_nxt    = cnt_q + 1'b1;
  assign in_ready_o = !flush_i && (!out_vld_q || out_ready_i);
  assign accept     = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      units_q   <= '0;
      cnt_q     <= '0;
      len_q     <= '0;
      out_vld_q <= 1'b0;
    end else begin
      if (out_vld_q && out_ready_i) out_vld_q <= 1'b0;
      if (flush_i) begin
        cnt_q <= '0;
      end else if (accept) begin
        units_q[cnt_q] <= in_data_i;
        if (cnt_q == '0) len_q <= in_len;
        if (cnt_nxt == need_len) begin
          cnt_q     <= '0;
          out_vld_q <= 1'b1;
        end else begin
          cnt_q <= cnt_nxt;
        end
      end
    end
  end

  bcode_field_extract i_extract (
    .fmt_i      (rec_fmt),
    .u_i        (units_q),
    .reg_a_o    (reg_a_o),
    .reg_b_o    (reg_b_o),
    .reg_c_o    (reg_c_o),
    .arg_cnt_o  (arg_cnt_o),
    .arg_regs_o (arg_regs_o),
    .arg_vld_o  (arg_vld_o),
    .imm_o      (imm_o),
    .index_o    (index_o)
  );

  assign out_valid_o = out_vld_q;
  assign op_o        = units_q[0][7:0];
  assign fmt_o       = rec_fmt;
  assign len_o       = fmt_len(rec_fmt);
  assign invalid_o   = rec_unused;
  assign payload_o   = (units_q[0][7:0] == 8'h00) && (units_q[0][15:8] != 8'h00);
endmodule

// File: rtl/bcode_fmt_decoder_chk.sv
module bcode_fmt_decoder_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        flush_i,
  input logic        in_valid_i,
  input logic [15:0] in_data_i,
  input logic        in_ready_o,
  input logic        out_valid_o,
  input logic        out_ready_i,
  input logic [7:0]  op_o,
  input logic [4:0]  fmt_o,
  input logic [2:0]  len_o,
  input logic [15:0] reg_a_o,
  input logic [15:0] reg_b_o,
  input logic [15:0] reg_c_o,
  input logic [7:0]  arg_cnt_o,
  input logic [19:0] arg_regs_o,
  input logic [4:0]  arg_vld_o,
  input logic [63:0] imm_o,
  input logic [31:0] index_o,
  input logic        invalid_o,
  input logic        payload_o
);
  // R10
  rec_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(op_o) && $stable(imm_o)
      && $stable(index_o) && $stable(reg_a_o));

  // R10
  stall_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |-> !in_ready_o);

  // R11
  flush_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> !in_ready_o);

  // R6
  unused_fmt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && invalid_o |-> len_o == 3'd1 && fmt_o == 5'd0 && imm_o == '0);

  // R7
  payload_hdr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && payload_o |-> op_o == 8'h00 && !invalid_o);

  // R1
  len_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> len_o >= 3'd1 && len_o <= 3'd5);

  // R4
  arg_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && fmt_o == 5'd21 |->
      $countones(arg_vld_o) == ((arg_cnt_o > 8'd5) ? 32'd5 : 32'(arg_cnt_o)));
endmodule

bind bcode_fmt_decoder bcode_fmt_decoder_chk i_chk (.*);

// File: tb/test_bcode_fmt_decoder.sv
`timescale 1ns/1ps
module test_bcode_fmt_decoder;
  logic        clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic        in_valid = 1'b0, out_ready = 1'b0;
  logic [15:0] in_data = '0;
  logic        in_ready, out_valid, invalid, payload;
  logic [7:0]  op, arg_cnt;
  logic [4:0]  fmt, arg_vld;
  logic [2:0]  len;
  logic [15:0] ra, rb, rc;
  logic [19:0] arg_regs;
  logic [63:0] imm;
  logic [31:0] idx;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0]  op;  logic [4:0]  fmt; logic [2:0] len;
    logic [15:0] ra, rb, rc;
    logic [7:0]  cnt; logic [19:0] regs; logic [4:0] vld;
    logic [63:0] imm; logic [31:0] idx;
    logic        inv, pay;
    string       tag;
  } exp_t;

  exp_t sb[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bcode_fmt_decoder i_bcode_fmt_decoder (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_ready_o(in_ready),
    .out_valid_o(out_valid), .out_ready_i(out_ready),
    .op_o(op), .fmt_o(fmt), .len_o(len), .reg_a_o(ra), .reg_b_o(rb), .reg_c_o(rc),
    .arg_cnt_o(arg_cnt), .arg_regs_o(arg_regs), .arg_vld_o(arg_vld),
    .imm_o(imm), .index_o(idx), .invalid_o(invalid), .payload_o(payload)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic exp_t mk(input logic [7:0] o, input logic [4:0] f, input logic [2:0] l, input string t);
    exp_t e;
    e.op = o; e.fmt = f; e.len = l; e.tag = t;
    e.ra = '0; e.rb = '0; e.rc = '0; e.cnt = '0; e.regs = '0; e.vld = '0;
    e.imm = '0; e.idx = '0; e.inv = 1'b0; e.pay = 1'b0;
    return e;
  endfunction

  task automatic put_unit(input logic [15:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = w;
    #5;
    while (!in_ready) begin
      @(negedge clk);
      #5;
    end
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send(input exp_t e, input int n, input logic [15:0] w0,
                      input logic [15:0] w1 = 0, input logic [15:0] w2 = 0,
                      input logic [15:0] w3 = 0, input logic [15:0] w4 = 0);
    sb.push_back(e);
    put_unit(w0);
    if (n > 1) put_unit(w1);
    if (n > 2) put_unit(w2);
    if (n > 3) put_unit(w3);
    if (n > 4) put_unit(w4);
  endtask

  // monitor / scoreboard
  initial begin
    bit         was_stalled = 1'b0;
    logic [7:0] held_op = '0;
    logic [63:0] held_imm = '0;
    forever begin
      @(negedge clk);
      out_ready = (cyc % 3) != 2;
      #5;
      if (rst_n) begin
        if (was_stalled) begin
          chk("R10", "held valid", 64'(out_valid), 64'd1);
          chk("R10", "held op", 64'(op), 64'(held_op));
          chk("R10", "held imm", imm, held_imm);
        end
        was_stalled = out_valid && !out_ready;
        held_op = op;
        held_imm = imm;
        if (was_stalled) chk("R10", "in_ready while stalled", 64'(in_ready), 64'd0);
        if (out_valid && out_ready) begin
          if (sb.size() == 0) begin
            chk("R11", "unexpected record", 64'(op), 64'hFFFF);
          end else begin
            exp_t e;
            e = sb.pop_front();
            chk(e.tag, "op", 64'(op), 64'(e.op));
            chk("R1", "fmt", 64'(fmt), 64'(e.fmt));
            chk("R1", "len", 64'(len), 64'(e.len));
            chk(e.tag, "reg_a", 64'(ra), 64'(e.ra));
            chk(e.tag, "reg_b", 64'(rb), 64'(e.rb));
            chk(e.tag, "reg_c", 64'(rc), 64'(e.rc));
            chk(e.tag, "arg_cnt", 64'(arg_cnt), 64'(e.cnt));
            if (e.fmt == 5'd21) chk(e.tag, "arg_regs", 64'(arg_regs), 64'(e.regs));
            chk(e.tag, "arg_vld", 64'(arg_vld), 64'(e.vld));
            chk(e.tag, "imm", imm, e.imm);
            chk(e.tag, "index", 64'(idx), 64'(e.idx));
            chk("R6", "invalid", 64'(invalid), 64'(e.inv));
            chk("R7", "payload", 64'(payload), 64'(e.pay));
          end
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    exp_t e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #5;
    chk("R12", "out_valid after reset", 64'(out_valid), 64'd0);
    chk("R12", "in_ready after reset", 64'(in_ready), 64'd1);

    e = mk(8'h00, 5'd0, 3'd1, "R7"); send(e, 1, 16'h0000);
    e = mk(8'h00, 5'd0, 3'd1, "R7"); e.pay = 1'b1; send(e, 1, 16'h0100);
    e = mk(8'h01, 5'd1, 3'd1, "R2"); e.ra = 16'd3; e.rb = 16'd5; send(e, 1, 16'h5301);
    e = mk(8'h12, 5'd2, 3'd1, "R8"); e.ra = 16'd2; e.imm = -64'sd3; send(e, 1, 16'hD212);
    e = mk(8'h03, 5'd17, 3'd3, "R2"); e.ra = 16'h1234; e.rb = 16'hABCD;
    send(e, 3, 16'h0003, 16'h1234, 16'hABCD);
    idle();
    e = mk(8'h15, 5'd9, 3'd2, "R9"); e.ra = 16'd7; e.imm = 64'hFFFF_FFFF_8001_0000;
    send(e, 2, 16'h0715, 16'h8001);
    e = mk(8'h19, 5'd9, 3'd2, "R9"); e.ra = 16'd8; e.imm = 64'h1234_0000_0000_0000;
    send(e, 2, 16'h0819, 16'h1234);
    e = mk(8'h14, 5'd18, 3'd3, "R3"); e.ra = 16'h0A; e.imm = 64'hFFFF_FFFF_9ABC_5678;
    send(e, 3, 16'h0A14, 16'h5678, 16'h9ABC);
    e = mk(8'h18, 5'd23, 3'd5, "R3"); e.ra = 16'h0B; e.imm = 64'h4444_3333_2222_1111;
    send(e, 5, 16'h0B18, 16'h1111, 16'h2222, 16'h3333, 16'h4444);
    e = mk(8'h28, 5'd4, 3'd1, "R8"); e.imm = -64'sd2; send(e, 1, 16'hFE28);
    e = mk(8'h2A, 5'd16, 3'd3, "R3"); e.imm = 64'hFFFF_FFFF_8000_0000;
    send(e, 3, 16'h002A, 16'h0000, 16'h8000);
    idle();
    e = mk(8'h34, 5'd13, 3'd2, "R8"); e.ra = 16'd1; e.rb = 16'd2; e.imm = -64'sd16;
    send(e, 2, 16'h2134, 16'hFFF0);
    e = mk(8'h90, 5'd11, 3'd2, "R2"); e.ra = 16'd5; e.rb = 16'd6; e.rc = 16'd7;
    send(e, 2, 16'h0590, 16'h0706);
    e = mk(8'hD8, 5'd12, 3'd2, "R8"); e.ra = 16'd3; e.rb = 16'd4; e.imm = -64'sd128;
    send(e, 2, 16'h03D8, 16'h8004);
    e = mk(8'hD1, 5'd14, 3'd2, "R8"); e.ra = 16'd1; e.rb = 16'd2; e.imm = 64'h7FFF;
    send(e, 2, 16'h21D1, 16'h7FFF);
    e = mk(8'h6E, 5'd21, 3'd3, "R4"); e.cnt = 8'd3; e.regs = 20'h9FEDC; e.vld = 5'b00111;
    e.idx = 32'h42; send(e, 3, 16'h396E, 16'h0042, 16'hFEDC);
    e = mk(8'h24, 5'd21, 3'd3, "R4"); e.cnt = 8'd5; e.regs = 20'hA4321; e.vld = 5'b11111;
    e.idx = 32'h1; send(e, 3, 16'h5A24, 16'h0001, 16'h4321);
    e = mk(8'h74, 5'd22, 3'd3, "R5"); e.cnt = 8'h10; e.idx = 32'hBEEF; e.rc = 16'h20;
    send(e, 3, 16'h1074, 16'hBEEF, 16'h0020);
    e = mk(8'h1B, 5'd20, 3'd3, "R3"); e.ra = 16'd4; e.idx = 32'h0002_0001;
    send(e, 3, 16'h041B, 16'h0001, 16'h0002);
    e = mk(8'h3E, 5'd0, 3'd1, "R6"); e.inv = 1'b1; send(e, 1, 16'h123E);
    e = mk(8'hFF, 5'd0, 3'd1, "R6"); e.inv = 1'b1; send(e, 1, 16'hFFFF);
    e = mk(8'h13, 5'd8, 3'd2, "R8"); e.ra = 16'h0C; e.imm = 64'hFFFF_FFFF_FFFF_8000;
    send(e, 2, 16'h0C13, 16'h8000);
    e = mk(8'h52, 5'd15, 3'd2, "R5"); e.ra = 16'd3; e.rb = 16'd4; e.idx = 32'h99;
    send(e, 2, 16'h4352, 16'h0099);

    // R11: partial 31i dropped by flush
    put_unit(16'h0014);
    put_unit(16'h1111);
    @(negedge clk);
    in_valid = 1'b0;
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    e = mk(8'h0E, 5'd0, 3'd1, "R11"); send(e, 1, 16'h000E);
    idle();

    for (int i = 0; i < 200 && sb.size() != 0; i++) @(negedge clk);
    repeat (5) @(negedge clk);
    chk("R11", "records left over", 64'(sb.size()), 64'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule